// File: doc/BRIEF.md
# Regulator Start-Up and Protection Sequencer

This block sequences the start-up and shutdown of a step-down switching regulator. A rising enable first wakes the voltage reference. Once the reference reports ready, switching begins and a digital soft-start code climbs from zero to full scale. The ramp is timed so that the whole climb takes about one millisecond at the configured clock. The ramp code feeds the regulation reference. The switching enable goes to the light-load/heavy-load mode controller, and a frequency-reduce select goes to the oscillator.

Three conditions keep the regulator shut down: a low enable, an active undervoltage-lockout flag, or a die temperature that has tripped the thermal limit. While shut down, both power switches are off and the output is discharged through a bleed switch. The thermal limit has hysteresis. It trips when the temperature code reaches `TRIP_C` and releases only when the code falls to `RESUME_C` (30 degrees lower by default). Whenever a fault clears, start-up is repeated from the reference-wake step with the ramp back at zero. All control inputs, the temperature code included, pass through two-flop synchronizers.

Top module: `reg_seq_ctrl`

## Requirements
- R1: During and after reset the block is shut down: `bleed_o`=1 and `ref_en_o`=`sw_en_o`=`slow_osc_o`=0, with `ramp_o`=0.
- R2: A high enable with no fault asserts `ref_en_o` exactly three clock edges after `en_i` rises, counting two synchronizer edges and one state edge. `sw_en_o` stays 0 and `ramp_o` stays 0 until the synchronized reference-ready flag is high.
- R3: With the reference ready, `sw_en_o` is 1 three edges after `ref_rdy_i` rises, and `ramp_o` goes up by exactly one every `STEP_CYC` cycles, where `STEP_CYC` = `CLK_KHZ`/(2^`RAMP_W`-1).
- R4: `ramp_o` stops at full scale (all ones) and holds there while switching continues.
- R5: A low enable shuts the block down and clears `ramp_o` to 0 three edges after `en_i` falls.
- R6: While `uvlo_i` is 1 the block stays shut down. After it clears, start-up restarts at reference wake with `ramp_o` at 0.
- R7: A temperature code of `TRIP_C` or more (unsigned, one count per degree) shuts the block down four edges later. A code one below `TRIP_C` has no effect.
- R8: After a thermal trip, the block stays shut down for any code above `RESUME_C`. At `RESUME_C` or below it restarts from reference wake with `ramp_o` at 0.
- R9: `bleed_o` and `sw_en_o` are never 1 in the same cycle.
- R10: `slow_osc_o` follows the synchronized short-circuit flag while switching and is 0 whenever `sw_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable request |
| uvlo_i | input | 1 | Supply undervoltage flag, 1 = fault |
| temp_i | input | TEMP_W | Die temperature code in degrees, unsigned |
| ref_rdy_i | input | 1 | Reference settled |
| short_i | input | 1 | Output short-circuit flag |
| ref_en_o | output | 1 | Reference enable |
| ramp_o | output | RAMP_W | Soft-start reference code |
| sw_en_o | output | 1 | Switching enable for the mode controller |
| bleed_o | output | 1 | Output discharge switch enable |
| slow_osc_o | output | 1 | Reduced oscillator frequency select |

## Verification
A fault can clear while the reference-ready flag is still high. The wake step and the start of the ramp then land on consecutive edges, and the ramp clear from the shut-down path and the first prescaler count meet at the same boundary. The bench provokes this by dropping the undervoltage flag with ready held high. It samples the edge where the reference wakes (ramp 0, no switching) and then the edge three cycles into the ramp (switching on, ramp still 0). In a second case, the short-circuit flag and the undervoltage flag are raised in the same cycle while the block is running. The bench confirms that the frequency select falls together with switching.

// File: rtl/reg_seq_pkg.sv
package reg_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_RAMP = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/seq_thermal.sv
module seq_thermal #(
  parameter int TEMP_W   = 8,
  parameter int TRIP_C   = 130,
  parameter int RESUME_C = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TripCode   = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] ResumeCode = TEMP_W'(RESUME_C);

  logic hot_q, hot_d;

  // latched once tripped; released only at or below resume code
  always_comb begin
    if (hot_q) hot_d = (temp_i > ResumeCode);
    else       hot_d = (temp_i >= TripCode);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hot_q <= 1'b0;
    else         hot_q <= hot_d;
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
  parameter int RAMP_W   = 6,
  parameter int STEP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  output logic [RAMP_W-1:0] code_o,
  output logic              full_o
);
  localparam int PRE_W = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;
  localparam logic [PRE_W-1:0]  PreLast = PRE_W'(STEP_CYC - 1);
  localparam logic [RAMP_W-1:0] CodeMax = '1;

  logic [PRE_W-1:0]  pre_q;
  logic [RAMP_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (run_i) begin
      if (pre_q == PreLast) begin
        pre_q <= '0;
        if (code_q != CodeMax) code_q <= code_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign code_o = code_q;
  assign full_o = (code_q == CodeMax);
endmodule

// File: rtl/reg_seq_ctrl.sv
module reg_seq_ctrl
  import reg_seq_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int RAMP_W   = 6,
  parameter int CLK_KHZ  = 50000,
  parameter int TRIP_C   = 130,
  parameter int RESUME_C = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              uvlo_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              ref_rdy_i,
  input  logic              short_i,
  output logic              ref_en_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              sw_en_o,
  output logic              bleed_o,
  output logic              slow_osc_o
);
  // CLK_KHZ cycles span 1 ms; spread them over the ramp steps
  localparam int RampSteps = (1 << RAMP_W) - 1;
  localparam int StepRaw   = CLK_KHZ / RampSteps;
  localparam int StepCyc   = (StepRaw < 2) ? 2 : StepRaw;
  localparam int SyncW     = TEMP_W + 4;

  logic [SyncW-1:0]  sync_d, sync_q;
  logic              en_s, uvlo_s, rdy_s, short_s;
  logic [TEMP_W-1:0] temp_s;
  logic              hot;
  logic              ramp_full;
  seq_state_e        state_q, state_d;

  assign sync_d = {en_i, uvlo_i, ref_rdy_i, short_i, temp_i};
  assign {en_s, uvlo_s, rdy_s, short_s, temp_s} = sync_q;

  seq_sync #(.W(SyncW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  seq_thermal #(
    .TEMP_W  (TEMP_W),
    .TRIP_C  (TRIP_C),
    .RESUME_C(RESUME_C)
  ) u_thermal (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .temp_i(temp_s),
    .hot_o (hot)
  );

  logic blocked;
  assign blocked = !en_s || uvlo_s || hot;

  always_comb begin
    state_d = state_q;
    if (blocked) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_WAKE;
        ST_WAKE: if (rdy_s) state_d = ST_RAMP;
        ST_RAMP: if (ramp_full) state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  // clear from next state so the code drops on the shutdown edge
  logic ramp_clr;
  assign ramp_clr = (state_d == ST_OFF) || (state_d == ST_WAKE);

  seq_ramp #(
    .RAMP_W  (RAMP_W),
    .STEP_CYC(StepCyc)
  ) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ramp_clr),
    .run_i (state_q == ST_RAMP),
    .code_o(ramp_o),
    .full_o(ramp_full)
  );

  assign ref_en_o   = (state_q != ST_OFF);
  assign sw_en_o    = (state_q == ST_RAMP) || (state_q == ST_RUN);
  assign bleed_o    = (state_q == ST_OFF);
  assign slow_osc_o = sw_en_o && short_s;
endmodule

// File: rtl/reg_seq_chk.sv
module reg_seq_chk #(
  parameter int RAMP_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_en_o,
  input logic [RAMP_W-1:0] ramp_o,
  input logic              sw_en_o,
  input logic              bleed_o,
  input logic              slow_osc_o
);
  localparam logic [RAMP_W-1:0] CodeMax = '1;

  assert_bleed_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_en_o && bleed_o));

  assert_ramp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> (ramp_o == '0));

  assert_sw_after_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> $past(ref_en_o));

  assert_ramp_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o |=> (!sw_en_o || ramp_o == $past(ramp_o) || ramp_o == $past(ramp_o) + 1'b1));

  assert_ramp_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && ramp_o == CodeMax) |=> (!sw_en_o || ramp_o == CodeMax));

  assert_slow_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_osc_o |-> sw_en_o);

  assert_ref_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_en_o) |-> !sw_en_o);
endmodule

bind reg_seq_ctrl reg_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_en_o  (ref_en_o),
  .ramp_o    (ramp_o),
  .sw_en_o   (sw_en_o),
  .bleed_o   (bleed_o),
  .slow_osc_o(slow_osc_o)
);

// File: tb/tb_reg_seq_ctrl.sv
`timescale 1ns/1ps
module tb_reg_seq_ctrl;
  localparam int TEMP_W = 8;
  localparam int RAMP_W = 4;
  localparam int NVEC   = 21;

  typedef struct packed {
    logic       en;
    logic       uvlo;
    logic [7:0] temp;
    logic       rdy;
    logic       shrt;
    logic [7:0] wt;
    logic       e_ref;
    logic       e_sw;
    logic       e_bleed;
    logic       e_slow;
    logic [3:0] e_ramp;
  } vec_t;

  // en uvlo temp rdy shrt wait | ref sw bleed slow ramp
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,8'd25, 1'b0,1'b0,8'd5,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 0  R1
    '{1'b1,1'b0,8'd25, 1'b0,1'b0,8'd2,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 1  R2 not yet
    '{1'b1,1'b0,8'd25, 1'b0,1'b0,8'd1,  1'b1,1'b0,1'b0,1'b0,4'd0},  // 2  R2 third edge
    '{1'b1,1'b0,8'd25, 1'b0,1'b0,8'd20, 1'b1,1'b0,1'b0,1'b0,4'd0},  // 3  R2 waits ready
    '{1'b1,1'b0,8'd25, 1'b1,1'b0,8'd3,  1'b1,1'b1,1'b0,1'b0,4'd0},  // 4  R3 switching on
    '{1'b1,1'b0,8'd25, 1'b1,1'b0,8'd8,  1'b1,1'b1,1'b0,1'b0,4'd2},  // 5  R3 two steps
    '{1'b1,1'b0,8'd25, 1'b1,1'b0,8'd60, 1'b1,1'b1,1'b0,1'b0,4'd15}, // 6  R4 full
    '{1'b1,1'b0,8'd25, 1'b1,1'b1,8'd2,  1'b1,1'b1,1'b0,1'b1,4'd15}, // 7  R10 slow
    '{1'b1,1'b0,8'd25, 1'b1,1'b0,8'd2,  1'b1,1'b1,1'b0,1'b0,4'd15}, // 8  R10 back
    '{1'b1,1'b0,8'd129,1'b1,1'b0,8'd6,  1'b1,1'b1,1'b0,1'b0,4'd15}, // 9  R7 below trip
    '{1'b1,1'b0,8'd130,1'b1,1'b0,8'd4,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 10 R7 trip
    '{1'b1,1'b0,8'd101,1'b1,1'b0,8'd8,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 11 R8 held
    '{1'b1,1'b0,8'd100,1'b1,1'b0,8'd4,  1'b1,1'b0,1'b0,1'b0,4'd0},  // 12 R8 resume
    '{1'b1,1'b0,8'd100,1'b1,1'b0,8'd70, 1'b1,1'b1,1'b0,1'b0,4'd15}, // 13 R4 full again
    '{1'b1,1'b1,8'd100,1'b1,1'b1,8'd3,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 14 R6 R10 off
    '{1'b1,1'b1,8'd100,1'b1,1'b1,8'd6,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 15 R6 held
    '{1'b1,1'b0,8'd100,1'b1,1'b0,8'd3,  1'b1,1'b0,1'b0,1'b0,4'd0},  // 16 R6 wake
    '{1'b1,1'b0,8'd100,1'b1,1'b0,8'd4,  1'b1,1'b1,1'b0,1'b0,4'd0},  // 17 R6 ramp from 0
    '{1'b0,1'b0,8'd140,1'b1,1'b0,8'd4,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 18 R5 disable
    '{1'b1,1'b0,8'd140,1'b1,1'b0,8'd8,  1'b0,1'b0,1'b1,1'b0,4'd0},  // 19 R7 hot blocks
    '{1'b1,1'b0,8'd100,1'b1,1'b0,8'd5,  1'b1,1'b1,1'b0,1'b0,4'd0}   // 20 R8 restart
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0, uvlo = 1'b0, rdy = 1'b0, shrt = 1'b0;
  logic [TEMP_W-1:0] temp = 8'd25;
  logic              ref_en, sw_en, bleed, slow;
  logic [RAMP_W-1:0] ramp;
  int                errors = 0;
  int                checks = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  reg_seq_ctrl #(
    .TEMP_W  (TEMP_W),
    .RAMP_W  (RAMP_W),
    .CLK_KHZ (60),
    .TRIP_C  (130),
    .RESUME_C(100)
  ) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .uvlo_i    (uvlo),
    .temp_i    (temp),
    .ref_rdy_i (rdy),
    .short_i   (shrt),
    .ref_en_o  (ref_en),
    .ramp_o    (ramp),
    .sw_en_o   (sw_en),
    .bleed_o   (bleed),
    .slow_osc_o(slow)
  );

  function automatic string req_of(int i);
    case (i)
      0:               return "R1";
      1, 2, 3:         return "R2";
      4, 5:            return "R3";
      6, 13:           return "R4";
      7, 8:            return "R10";
      9, 10, 19:       return "R7";
      11, 12, 20:      return "R8";
      14, 15, 16, 17:  return "R6";
      18:              return "R5";
      default:         return "R?";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    #2;
    // R1: outputs while reset is held
    chk("R1", "bleed in reset", int'(bleed), 1);
    chk("R1", "ref in reset", int'(ref_en), 0);
    chk("R1", "sw in reset", int'(sw_en), 0);
    chk("R1", "ramp in reset", int'(ramp), 0);
    step(2);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NVEC; i++) begin
      en   = VECS[i].en;
      uvlo = VECS[i].uvlo;
      temp = VECS[i].temp;
      rdy  = VECS[i].rdy;
      shrt = VECS[i].shrt;
      step(int'(VECS[i].wt));
      chk(req_of(i), $sformatf("row %0d ref_en", i), int'(ref_en), int'(VECS[i].e_ref));
      chk(req_of(i), $sformatf("row %0d sw_en", i), int'(sw_en), int'(VECS[i].e_sw));
      chk(req_of(i), $sformatf("row %0d bleed", i), int'(bleed), int'(VECS[i].e_bleed));
      chk(req_of(i), $sformatf("row %0d slow", i), int'(slow), int'(VECS[i].e_slow));
      chk(req_of(i), $sformatf("row %0d ramp", i), int'(ramp), int'(VECS[i].e_ramp));
      // R9: never bleed while switching
      chk("R9", $sformatf("row %0d exclusive", i), int'(bleed && sw_en), 0);
    end

    // R5: disable from a running state clears the ramp in exactly three edges
    step(70);
    chk("R4", "full before disable", int'(ramp), 15);
    en = 1'b0;
    step(2);
    chk("R5", "still running after two edges", int'(sw_en), 1);
    step(1);
    chk("R5", "off after three edges", int'(bleed), 1);
    chk("R5", "ramp cleared", int'(ramp), 0);

    // R1: asynchronous reset while running
    en = 1'b1;
    step(80);
    chk("R4", "full before reset", int'(ramp), 15);
    rst_n = 1'b0;
    #1;
    chk("R1", "bleed on async reset", int'(bleed), 1);
    chk("R1", "sw off on async reset", int'(sw_en), 0);
    chk("R1", "ramp zero on async reset", int'(ramp), 0);
    step(2);
    rst_n = 1'b1;
    step(1);

    done = 1'b1;
    finish_run();
  end
endmodule